// File: doc/BRIEF.md
# Low-Side Driver Bring-Up Sequencer

This block takes a four-channel, serially configured low-side driver from power-up to an operating state. After a `start` pulse it holds the driver's active-low reset pin low for one millisecond, releases it, and waits one more millisecond. It then runs a fixed list of register accesses through a request port served by an external serial frame engine. It reads the identity register and checks its code. It switches on direct drive for all channels and runs the diagnostic read-and-clear pass twice. It sets the output-enable flag in the global status register. As the very last step it raises the hardware enable pin.

The block ends in one of two latched results: `init_done` on success, or `init_error` when the identity code does not match. Once `init_done` is set, the per-channel user requests pass to the direct-drive pins. These pins are active low, so a channel that is on drives its pin low. Until then every direct-drive pin is held high and every channel is off. The length of one millisecond is derived from the `CLK_HZ` parameter.

Top module: `drv_bringup`

## Requirements
- R1: After synchronous reset the outputs are: `drv_reset_n`=1, `drv_hw_en`=0, all `drv_dd_n` bits 1, `init_done`=0, `init_error`=0 and `req_valid`=0.
- R2: A start that is accepted drives `drv_reset_n` low for exactly MS_CYCLES clock cycles, where MS_CYCLES = CLK_HZ/1000. It then drives it high, and the first request is raised exactly MS_CYCLES cycles after that. `req_valid` is never high while `drv_reset_n` is low.
- R3: `req_valid` (with `req_write`=1 for a write and 0 for a read, `req_addr` 7 bits, `req_wdata` 8 bits and zero for reads) stays high with its fields unchanged until a clock edge samples `rsp_valid`=1. On that edge it drops, and it stays low for at least one cycle before the next request.
- R4: The first request reads address 0x08. If bits [7:0] of `rsp_data` are not 0xB1, then `init_error` rises on the edge that completes the read. After that no further request is issued and `drv_hw_en` stays low. Bits [15:8] are ignored.
- R5: The second request writes 0x0F (one bit per channel) to address 0x01.
- R6: Two identical diagnostic passes follow. Each pass reads 0x04, 0x05 and 0x06, then writes 0x00 to 0x04, 0x05 and 0x06, in that order.
- R7: The last request writes 0x80 to address 0x07. `drv_hw_en` and `init_done` both rise on the edge that completes this write, and `drv_hw_en` is never high while `init_done` is low. The sequence has 15 requests in total.
- R8: While `init_done` is high, each `drv_dd_n[i]` equals the inverse of `ch_on[i]`, one clock cycle after `ch_on` is sampled.
- R9: While `init_done` is low, including the error state, `ch_on` has no effect and every `drv_dd_n` bit is 1. The only exception is the single cycle right after a restart from the done state.
- R10: `init_done` and `init_error` are never high together, and each stays set until the next accepted start. A start is accepted only when idle, done or failed; a start during the sequence is ignored. An accepted start clears both flags and `drv_hw_en` on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin (or restart) the bring-up sequence |
| ch_on | input | NUM_CH | User request per channel, 1 = on |
| req_valid | output | 1 | Register access request pending |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 7 | Register address |
| req_wdata | output | 8 | Write data (zero on reads) |
| rsp_valid | input | 1 | Frame engine completes the pending request |
| rsp_data | input | 16 | Response word; low byte carries read data |
| drv_reset_n | output | 1 | Active-low driver reset |
| drv_hw_en | output | 1 | Driver hardware enable |
| drv_dd_n | output | NUM_CH | Active-low direct-drive pins |
| init_done | output | 1 | Latched: bring-up completed |
| init_error | output | 1 | Latched: identity mismatch |

## Verification
Each result is due at a fixed cycle, and the bench samples it there:
- The status flags, `drv_hw_en` and the idle gap are due one edge after the response that triggers them. The bench samples on the falling edge that follows that response and compares against the cycle number it recorded for the response.
- The reset-low time and the release-to-first-request time are counted in falling edges and must each equal MS_CYCLES exactly.
- A pin's answer to `ch_on` is due one edge after the input changes. The sweeps therefore change the input on one falling edge and read the pins on the next.
- The bench's responder varies its response latency from zero to several cycles. This shows that each request stays stable for as long as the response is withheld.

// File: rtl/drv_pkg.sv
package drv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RST_LOW,
    ST_RST_WAIT,
    ST_WAIT,
    ST_GAP,
    ST_RUN,
    ST_FAIL
  } seq_state_e;

  typedef struct packed {
    logic       wr;
    logic [6:0] addr;
    logic [7:0] data;
  } reg_req_t;

  localparam logic [6:0] ADDR_CFG       = 7'h01;
  localparam logic [6:0] ADDR_DIAG_BASE = 7'h04;
  localparam logic [6:0] ADDR_GSTAT     = 7'h07;
  localparam logic [6:0] ADDR_ID        = 7'h08;
  localparam int         DIAG_REGS      = 3;
  localparam logic [7:0] GSTAT_OUT_EN   = 8'h80;

endpackage

// File: rtl/drv_ms_timer.sv
module drv_ms_timer #(
  parameter int CYCLES = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  output logic zero
);
  localparam int W = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= W'(CYCLES - 1);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/drv_step_table.sv
module drv_step_table
  import drv_pkg::*;
#(
  parameter int NUM_CH      = 4,
  parameter int DIAG_PASSES = 2,
  parameter int IDX_W       = 4
) (
  input  logic [IDX_W-1:0] idx,
  output reg_req_t         req,
  output logic             last
);
  localparam int         PASS_LEN   = 2 * DIAG_REGS;
  localparam int         NSTEPS     = 3 + PASS_LEN * DIAG_PASSES;
  localparam logic [7:0] CFG_DIRECT = 8'((1 << NUM_CH) - 1);

  always_comb begin
    int k;
    int slot;
    k    = int'(idx) - 2;
    slot = (k < 0) ? 0 : (k % PASS_LEN);
    req  = '0;
    last = 1'b0;
    if (idx == '0) begin
      req.wr   = 1'b0;
      req.addr = ADDR_ID;
    end else if (int'(idx) == 1) begin
      req.wr   = 1'b1;
      req.addr = ADDR_CFG;
      req.data = CFG_DIRECT;
    end else if (int'(idx) >= NSTEPS - 1) begin
      req.wr   = 1'b1;
      req.addr = ADDR_GSTAT;
      req.data = GSTAT_OUT_EN;
      last     = 1'b1;
    end else begin
      req.wr   = (slot >= DIAG_REGS);
      req.addr = ADDR_DIAG_BASE + 7'(slot % DIAG_REGS);
      req.data = 8'h00;
    end
  end

endmodule

// File: rtl/drv_req_port.sv
module drv_req_port
  import drv_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       issue,
  input  reg_req_t   req_in,
  input  logic       rsp_valid,
  output logic       req_valid,
  output logic       req_write,
  output logic [6:0] req_addr,
  output logic [7:0] req_wdata,
  output logic       accepted
);
  always_ff @(posedge clk) begin
    if (rst) begin
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else if (issue) begin
      req_valid <= 1'b1;
      req_write <= req_in.wr;
      req_addr  <= req_in.addr;
      req_wdata <= req_in.data;
    end else if (req_valid && rsp_valid) begin
      req_valid <= 1'b0;
    end
  end

  assign accepted = req_valid && rsp_valid;

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !rsp_valid) |=> (req_valid && $stable(req_addr) &&
                                   $stable(req_wdata) && $stable(req_write)));

  // R3
  req_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && rsp_valid) |=> !req_valid);

endmodule

// File: rtl/drv_pin_stage.sv
module drv_pin_stage #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pass_en,
  input  logic [NUM_CH-1:0] ch_on,
  output logic [NUM_CH-1:0] dd_n
);
  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) dd_n[i] <= 1'b1;
      else     dd_n[i] <= pass_en ? ~ch_on[i] : 1'b1;
    end
  end

  // R9
  pins_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!pass_en && !$past(pass_en)) |=> (&dd_n));

  // R8
  pins_follow_chk: assert property (@(posedge clk) disable iff (rst)
    pass_en |=> (dd_n == ~$past(ch_on)));

endmodule

// File: rtl/drv_bringup.sv
module drv_bringup
  import drv_pkg::*;
#(
  parameter int         CLK_HZ      = 200_000_000,
  parameter int         NUM_CH      = 4,
  parameter int         DIAG_PASSES = 2,
  parameter logic [7:0] ID_CODE     = 8'hB1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [NUM_CH-1:0] ch_on,
  output logic              req_valid,
  output logic              req_write,
  output logic [6:0]        req_addr,
  output logic [7:0]        req_wdata,
  input  logic              rsp_valid,
  input  logic [15:0]       rsp_data,
  output logic              drv_reset_n,
  output logic              drv_hw_en,
  output logic [NUM_CH-1:0] drv_dd_n,
  output logic              init_done,
  output logic              init_error
);
  localparam int MS_CYCLES = (CLK_HZ / 1000 > 0) ? (CLK_HZ / 1000) : 1;
  localparam int NSTEPS    = 3 + 2 * DIAG_REGS * DIAG_PASSES;
  localparam int IDX_W     = $clog2(NSTEPS);

  seq_state_e       st;
  logic [IDX_W-1:0] idx;
  logic             rst_n_q, hwen_q, done_q, err_q;
  logic             tmr_zero, tmr_load;
  logic             go, issue, accepted, last_step, id_ok;
  reg_req_t         step_req;
  logic             unused_rsp_hi;

  assign unused_rsp_hi = ^rsp_data[15:8];
  assign id_ok         = (rsp_data[7:0] == ID_CODE);
  assign go            = start && (st == ST_IDLE || st == ST_RUN || st == ST_FAIL);
  assign tmr_load      = go || (st == ST_RST_LOW && tmr_zero);
  assign issue         = (st == ST_RST_WAIT && tmr_zero) || (st == ST_GAP);

  drv_ms_timer #(.CYCLES(MS_CYCLES)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (tmr_load),
    .zero (tmr_zero)
  );

  drv_step_table #(
    .NUM_CH      (NUM_CH),
    .DIAG_PASSES (DIAG_PASSES),
    .IDX_W       (IDX_W)
  ) u_table (
    .idx  (idx),
    .req  (step_req),
    .last (last_step)
  );

  drv_req_port u_port (
    .clk       (clk),
    .rst       (rst),
    .issue     (issue),
    .req_in    (step_req),
    .rsp_valid (rsp_valid),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .accepted  (accepted)
  );

  drv_pin_stage #(.NUM_CH(NUM_CH)) u_pins (
    .clk     (clk),
    .rst     (rst),
    .pass_en (done_q),
    .ch_on   (ch_on),
    .dd_n    (drv_dd_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      idx     <= '0;
      rst_n_q <= 1'b1;
      hwen_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (go) begin
      st      <= ST_RST_LOW;
      idx     <= '0;
      rst_n_q <= 1'b0;
      hwen_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      unique case (st)
        ST_RST_LOW: begin
          if (tmr_zero) begin
            st      <= ST_RST_WAIT;
            rst_n_q <= 1'b1;
          end
        end
        ST_RST_WAIT: begin
          if (tmr_zero) st <= ST_WAIT;
        end
        ST_GAP: st <= ST_WAIT;
        ST_WAIT: begin
          if (accepted) begin
            if (idx == '0 && !id_ok) begin
              st    <= ST_FAIL;
              err_q <= 1'b1;
            end else if (last_step) begin
              st     <= ST_RUN;
              done_q <= 1'b1;
              hwen_q <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
              st  <= ST_GAP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign drv_reset_n = rst_n_q;
  assign drv_hw_en   = hwen_q;
  assign init_done   = done_q;
  assign init_error  = err_q;

  // R10
  done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(init_done && init_error));

  // R7
  hwen_needs_done_chk: assert property (@(posedge clk) disable iff (rst)
    drv_hw_en |-> init_done);

  // R2
  no_access_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    !drv_reset_n |-> !req_valid);

  // R10
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (start && req_valid) |=> drv_reset_n);

  // R4
  fail_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    init_error |-> (!req_valid && !drv_hw_en));

endmodule

// File: tb/drv_bringup_test.sv
`timescale 1ns/100ps
module drv_bringup_test;
  localparam int CLK_HZ = 10_000;
  localparam int MS     = CLK_HZ / 1000;
  localparam int NREQ   = 15;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  ch_on = 4'h0;
  logic        req_valid, req_write;
  logic [6:0]  req_addr;
  logic [7:0]  req_wdata;
  logic        rsp_valid = 1'b0;
  logic [15:0] rsp_data = 16'h0;
  logic        drv_reset_n, drv_hw_en, init_done, init_error;
  logic [3:0]  drv_dd_n;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int rsp_cyc = 0;
  int n_req = 0;
  int lat_cur = 0;
  int lat_left = 0;
  bit busy = 0;
  logic [7:0]  id_cur = 8'hB1;
  logic [15:0] log_ent [0:31];

  always #2.5 clk = ~clk;

  drv_bringup #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst(rst), .start(start), .ch_on(ch_on),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .drv_reset_n(drv_reset_n), .drv_hw_en(drv_hw_en), .drv_dd_n(drv_dd_n),
    .init_done(init_done), .init_error(init_error)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_step(input int i);
    int j;
    if (i == 0)  return {1'b0, 7'h08, 8'h00};
    if (i == 1)  return {1'b1, 7'h01, 8'h0F};
    if (i == 14) return {1'b1, 7'h07, 8'h80};
    j = (i - 2) % 6;
    if (j < 3) return {1'b0, 7'(4 + j), 8'h00};
    return {1'b1, 7'(4 + j - 3), 8'h00};
  endfunction

  task automatic fire();
    rsp_valid = 1'b1;
    rsp_data  = (log_ent[n_req-1][14:8] == 7'h08) ? {8'hC3, id_cur} : 16'h0000;
    rsp_cyc   = cyc;
  endtask

  // one falling edge: sample outputs, then act as the frame engine
  task automatic step_cycle();
    @(negedge clk);
    cyc++;
    if (rsp_valid) begin
      rsp_valid = 1'b0;
      busy = 0;
      chk(!req_valid, "R3 idle gap after response", 32'(req_valid), 0);
    end else if (!busy && req_valid) begin
      if (n_req < 32) log_ent[n_req] = {req_write, req_addr, req_wdata};
      n_req++;
      busy = 1;
      lat_left = lat_cur;
      if (lat_left == 0) fire();
    end else if (busy) begin
      chk(req_valid && {req_write, req_addr, req_wdata} == log_ent[n_req-1],
          "R3 request held stable", {req_valid, req_write, req_addr, req_wdata},
          {1'b1, log_ent[n_req-1]});
      if (lat_left > 0) lat_left--;
      if (lat_left == 0) fire();
    end
  endtask

  task automatic run_seq(input logic [7:0] id, input int lat, input bit poke, input bit expect_ok);
    int low_cnt = 0;
    int gap_cnt = 0;
    int it = 0;
    bit reset_again = 0;
    id_cur = id;
    lat_cur = lat;
    n_req = 0;
    ch_on = 4'h0;
    start = 1'b1;
    step_cycle();
    start = 1'b0;
    chk(!init_done && !init_error && !drv_hw_en && !drv_reset_n, "R10 start clears flags",
        {init_done, init_error, drv_hw_en, drv_reset_n}, 0);
    low_cnt = 1;
    while (!init_done && !init_error && it < 3000) begin
      ch_on = 4'(it);
      if (poke && n_req == 5) start = 1'b1;
      step_cycle();
      start = 1'b0;
      it++;
      if (!drv_reset_n) begin
        if (n_req > 0) reset_again = 1;
        else low_cnt++;
      end else if (n_req == 0 && !req_valid) gap_cnt++;
      if (!init_done) begin
        chk(&drv_dd_n, "R9 pins off before done", drv_dd_n, 4'hF);
        chk(!drv_hw_en, "R7 enable low before done", drv_hw_en, 0);
      end
    end
    chk(low_cnt == MS, "R2 reset low length", low_cnt, MS);
    chk(gap_cnt == MS, "R2 release to first request", gap_cnt, MS);
    chk(!reset_again, "R10 start during sequence ignored", reset_again, 0);
    chk(!(init_done && init_error), "R10 flags exclusive", {init_done, init_error}, 0);
    chk(cyc == rsp_cyc + 1, "R7 flag one edge after last response", cyc, rsp_cyc + 1);
    if (expect_ok) begin
      chk(init_done && drv_hw_en, "R7 done with enable", {init_done, drv_hw_en}, 2'b11);
      chk(n_req == NREQ, "R7 request count", n_req, NREQ);
      for (int i = 0; i < NREQ; i++)
        chk(log_ent[i] == exp_step(i), (i == 0) ? "R4 id read" : (i == 1) ? "R5 config write" :
            (i == 14) ? "R7 status write" : "R6 diag pass", log_ent[i], exp_step(i));
    end else begin
      chk(init_error && !init_done, "R4 error on bad id", {init_error, init_done}, 2'b10);
      chk(n_req == 1 && log_ent[0] == exp_step(0), "R4 only id read issued", n_req, 1);
      for (int i = 0; i < 30; i++) begin
        ch_on = 4'(i);
        step_cycle();
        chk(!req_valid && !drv_hw_en && init_error && drv_reset_n && (&drv_dd_n),
            "R9 error state quiet", {req_valid, drv_hw_en, init_error, drv_reset_n, drv_dd_n},
            {4'b0011, 4'hF});
      end
    end
  endtask

  initial begin
    #(5.0 * 180000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) step_cycle();
    rst = 1'b0;
    step_cycle();
    chk(drv_reset_n && !drv_hw_en && (&drv_dd_n) && !init_done && !init_error && !req_valid,
        "R1 reset state", {drv_reset_n, drv_hw_en, drv_dd_n, init_done, init_error, req_valid},
        {2'b10, 4'hF, 3'b000});
    for (int v = 0; v < 16; v++) begin
      ch_on = 4'(v);
      step_cycle();
      chk(drv_dd_n == 4'hF, "R9 idle ignores ch_on", drv_dd_n, 4'hF);
    end
    run_seq(8'hB1, 0, 0, 1);
    for (int v = 0; v < 16; v++) begin
      ch_on = 4'(v);
      step_cycle();
      chk(drv_dd_n == ~4'(v), "R8 pins follow inverted", drv_dd_n, ~4'(v));
    end
    run_seq(8'hB1, 3, 1, 1);
    run_seq(8'hB2, 2, 0, 0);
    run_seq(8'hB1, 1, 0, 1);
    chk(!init_error, "R10 restart clears error", init_error, 0);
    run_seq(8'h31, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule